// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. Software first sets a PHY address and a PHY register address. For a write it also sets 16 bits of data. It then writes a command. The block divides the system clock down to make the management clock. It shifts out a clause-22 frame, which may start with an optional run of 32 preamble ones. For a read it releases the data line from the turnaround onward and captures the 16 bits the PHY returns.

A scan command reads the selected PHY register again and again. Each result updates the receive data register, and the link-fail flag follows the inverse of bit 2 of the latest result. An invalid flag stays set from the scan command until the first scan frame has completed. A busy flag covers each operation. Software writes zero to the command register to end an operation or to stop a scan.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, the status, command and receive data registers read 0, the mode register reads divider 100 with the preamble enabled, `mdio_oe` is low and `mdio_out` is high.
- R2: Registers are selected by `reg_addr` and read back one clock after the address is presented:
  - 0, mode: bits 7:1 are the divider, bit 0 is ignored and reads 0, and bit 8 drops the preamble.
  - 1, command: bit 0 is scan, bit 1 is read, bit 2 is write.
  - 2, address: bits 4:0 are the PHY address and bits 12:8 the PHY register.
  - 3, transmit data: bits 15:0.
  - 4, receive data: bits 15:0.
  - 5, status: bit 0 is link fail, bit 1 is busy, bit 2 is invalid.
  - Unlisted bits read 0.
- R3: The MDC period equals the mode divider with bit 0 cleared, in system clocks. A value of 0 or 1 gives a period of 2.
- R4: A write frame is 32 ones (unless the preamble is dropped), then start 01, opcode 01, the PHY address, the register address, turnaround 10 and the data, each field MSB first. `mdio_oe` is high for all 64 bit times, or 32 without the preamble.
- R5: A read frame uses opcode 10. `mdio_oe` is high only for the preamble and the first 14 frame bits, which is 46 bit times or 14 without the preamble. The 16 data bits are sampled on MDC rising edges into the receive data register. With no PHY answering, the pulled-up line reads FFFF.
- R6: `mdio_out` and `mdio_oe` change only at the clock edge where MDC falls.
- R7: Busy reads 1 from the clock after a nonzero command write until the frame ends. A read or write runs exactly once, and no further frame starts until the command register is written again.
- R8: When several command bits are set, scan wins over read and read wins over write.
- R9: While the scan bit stays set, read frames of the selected register repeat, and each one updates the receive data register. Invalid is set by the scan command write and cleared when the first scan frame ends.
- R10: Link fail is the inverse of bit 2 of the most recent scan result. It changes only when a scan frame ends.
- R11: Writing zero during a scan lets the current frame finish. Busy then drops and no more frames start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Data line as seen at the pin |

## Verification
The bench drives frames against a PHY model and counts the MDC edges during which the block drives the line. A turnaround released one bit late or early, or a preamble not suppressed, therefore shows up as a wrong count or as corrupted read data. The bench checks that a finished read or write is not replayed while the command register still holds it; a design that relaunches on a standing command would keep toggling the enable. In scan mode the PHY's status bit 2 is flipped between frames to confirm that link fail follows the latest result. The bench also confirms that clearing the command stops the loop only after the frame in flight. Odd and zero divider values are timed directly, which catches a divider that honours bit 0 or stalls on zero.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_WAIT  = 2'd1,
    ENG_SHIFT = 2'd2
  } eng_state_e;

  localparam logic [1:0] FRM_START = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] TA_DRIVE  = 2'b10;
  localparam logic [1:0] TA_FLOAT  = 2'b11;

  localparam logic [2:0] IDX_MODE = 3'd0;
  localparam logic [2:0] IDX_CMD  = 3'd1;
  localparam logic [2:0] IDX_ADDR = 3'd2;
  localparam logic [2:0] IDX_TXD  = 3'd3;
  localparam logic [2:0] IDX_RXD  = 3'd4;
  localparam logic [2:0] IDX_STAT = 3'd5;

  localparam int CMD_SCAN  = 0;
  localparam int CMD_READ  = 1;
  localparam int CMD_WRITE = 2;
endpackage

// File: rtl/mdio_clkgen.sv
// Free-running management clock; half period = divider bits [DIV_W-1:1].
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-2:0] half_in,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half_eff;
  logic [HALF_W-1:0] cnt;
  logic              term;

  assign half_eff  = (half_in == '0) ? HALF_W'(1) : half_in;
  assign term      = (cnt >= half_eff - HALF_W'(1));
  assign tick_rise = term & ~mdc;
  assign tick_fall = term & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
// Serializes one management frame; drives on MDC fall, samples on MDC rise.
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_op,
  input  logic              no_pre,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int HDR_W = 4 + 2 * ADDR_W;
  localparam int TA_W  = 2;
  localparam int FRM_W = HDR_W + TA_W + DATA_W;
  localparam int TOT_W = PRE_LEN + FRM_W;
  localparam int CNT_W = $clog2(TOT_W + 1);
  localparam logic [CNT_W-1:0] N_FULL    = CNT_W'(TOT_W);
  localparam logic [CNT_W-1:0] N_SHORT   = CNT_W'(FRM_W);
  localparam logic [CNT_W-1:0] FLOAT_OFS = CNT_W'(TA_W + DATA_W);
  localparam logic [CNT_W-1:0] SAMP_OFS  = CNT_W'(DATA_W - 1);

  eng_state_e        state;
  logic [TOT_W-1:0]  shreg;
  logic [CNT_W-1:0]  nbits;
  logic [CNT_W-1:0]  idx;
  logic              rd_q;
  logic [FRM_W-1:0]  frame;

  assign frame = {FRM_START, (rd_op ? OPC_READ : OPC_WRITE), phy_addr, reg_addr,
                  (rd_op ? TA_FLOAT : TA_DRIVE), (rd_op ? {DATA_W{1'b1}} : wdata)};
  assign active = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      shreg    <= '0;
      nbits    <= '0;
      idx      <= '0;
      rd_q     <= 1'b0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            shreg <= no_pre ? {frame, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, frame};
            nbits <= no_pre ? N_SHORT : N_FULL;
            idx   <= '0;
            rd_q  <= rd_op;
            state <= ENG_WAIT;
          end
        end
        ENG_WAIT, ENG_SHIFT: begin
          if (tick_fall) begin
            if (state == ENG_SHIFT && idx == nbits) begin
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b1;
              done     <= 1'b1;
              state    <= ENG_IDLE;
            end else begin
              mdio_out <= shreg[TOT_W-1];
              shreg    <= {shreg[TOT_W-2:0], 1'b0};
              mdio_oe  <= !(rd_q && idx >= nbits - FLOAT_OFS);
              idx      <= idx + CNT_W'(1);
              state    <= ENG_SHIFT;
            end
          end else if (tick_rise && state == ENG_SHIFT && rd_q &&
                       idx >= nbits - SAMP_OFS) begin
            rdata <= {rdata[DATA_W-2:0], mdio_in};
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int DIV_RESET = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int REG_LSB = 8;
  localparam logic [DIV_W-1:0] DIV_RST_V = DIV_W'(DIV_RESET);

  logic [DIV_W-2:0]  div_half_q;
  logic              nopre_q;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] rega_q;
  logic [DATA_W-1:0] txd_q;
  logic [DATA_W-1:0] rxd_q;
  logic              pend_q;
  logic              frame_scan_q;
  logic              frame_rd_q;
  logic              link_fail_q;
  logic              invalid_q;

  logic              tick_rise, tick_fall;
  logic              eng_active, eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              launch, launch_rd, busy, wr_cmd;
  logic [31:0]       rd_next;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[31:DATA_W];

  assign wr_cmd    = reg_we && (reg_addr == IDX_CMD);
  assign launch    = pend_q && !eng_active;
  assign launch_rd = cmd_q[CMD_SCAN] | cmd_q[CMD_READ];
  assign busy      = pend_q | eng_active;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .half_in   (div_half_q),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  mdio_frame_eng #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (launch),
    .rd_op     (launch_rd),
    .no_pre    (nopre_q),
    .phy_addr  (phy_q),
    .reg_addr  (rega_q),
    .wdata     (txd_q),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .mdio_in   (mdio_in),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .active    (eng_active),
    .done      (eng_done),
    .rdata     (eng_rdata)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      div_half_q <= DIV_RST_V[DIV_W-1:1];
      nopre_q    <= 1'b0;
      cmd_q      <= '0;
      phy_q      <= '0;
      rega_q     <= '0;
      txd_q      <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        IDX_MODE: begin
          div_half_q <= reg_wdata[DIV_W-1:1];
          nopre_q    <= reg_wdata[DIV_W];
        end
        IDX_CMD:  cmd_q <= reg_wdata[2:0];
        IDX_ADDR: begin
          phy_q  <= reg_wdata[ADDR_W-1:0];
          rega_q <= reg_wdata[REG_LSB +: ADDR_W];
        end
        IDX_TXD:  txd_q <= reg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  // Command sequencing: single shot for read/write, repeat while scanning
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      frame_scan_q <= 1'b0;
      frame_rd_q   <= 1'b0;
    end else begin
      if (wr_cmd)
        pend_q <= |reg_wdata[2:0];
      else if (launch && !cmd_q[CMD_SCAN])
        pend_q <= 1'b0;
      if (launch) begin
        frame_scan_q <= cmd_q[CMD_SCAN];
        frame_rd_q   <= launch_rd;
      end
    end
  end

  // Results and status
  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_q       <= '0;
      link_fail_q <= 1'b0;
      invalid_q   <= 1'b0;
    end else begin
      if (eng_done && frame_rd_q)
        rxd_q <= eng_rdata;
      if (eng_done && frame_scan_q)
        link_fail_q <= ~eng_rdata[2];
      if (wr_cmd && reg_wdata[CMD_SCAN])
        invalid_q <= 1'b1;
      else if (eng_done && frame_scan_q)
        invalid_q <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      IDX_MODE: begin
        rd_next[DIV_W-1:1] = div_half_q;
        rd_next[DIV_W]     = nopre_q;
      end
      IDX_CMD:  rd_next[2:0] = cmd_q;
      IDX_ADDR: begin
        rd_next[ADDR_W-1:0]         = phy_q;
        rd_next[REG_LSB +: ADDR_W]  = rega_q;
      end
      IDX_TXD:  rd_next[DATA_W-1:0] = txd_q;
      IDX_RXD:  rd_next[DATA_W-1:0] = rxd_q;
      IDX_STAT: begin
        rd_next[0] = link_fail_q;
        rd_next[1] = busy;
        rd_next[2] = invalid_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_out,
  input logic mdio_oe,
  input logic busy,
  input logic eng_done,
  input logic frame_scan,
  input logic invalid,
  input logic link_fail
);
  // R7
  oe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  // R6
  out_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_out) |-> $fell(mdc));

  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $fell(mdc));

  // R9
  scan_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done && frame_scan) |=> !invalid);

  // R10
  link_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_fail) |-> $past(eng_done && frame_scan));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mdc        (mdc),
  .mdio_out   (mdio_out),
  .mdio_oe    (mdio_oe),
  .busy       (busy),
  .eng_done   (eng_done),
  .frame_scan (frame_scan_q),
  .invalid    (invalid_q),
  .link_fail  (link_fail_q)
);

// File: tb/mdio_mgmt_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_tb;
  localparam logic [4:0] PHY_ID = 5'd3;
  localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                         A_TXD = 3'd3, A_RXD = 3'd4, A_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b1;
  logic [15:0] phy_regs [32];
  wire         mdio_line = mdio_oe ? mdio_out : (phy_oe ? phy_val : 1'b1);

  int checks = 0;
  int errors = 0;
  int oe_edges = 0;
  int r6_bad = 0;
  bit finished = 1'b0;
  logic prev_out, prev_oe, prev_mdc;

  always #5 clk = ~clk;

  mdio_mgmt u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .mdio_in   (mdio_line)
  );

  always @(posedge mdc) if (mdio_oe) oe_edges <= oe_edges + 1;

  // R6 monitor: drive changes only where mdc fell
  always @(negedge clk) begin
    if (!rst && ((mdio_out !== prev_out) || (mdio_oe !== prev_oe)) &&
        !(prev_mdc === 1'b1 && mdc === 1'b0))
      r6_bad = r6_bad + 1;
    prev_out <= mdio_out;
    prev_oe  <= mdio_oe;
    prev_mdc <= mdc;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_stat(input int bitn, input logic val, input string tag);
    logic [31:0] s;
    bit ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STAT, s);
      if (s[bitn] === val) begin ok = 1'b1; break; end
    end
    if (!ok) chk({tag, " wait timeout"}, s[bitn], val);
  endtask

  // PHY model: samples on MDC rise, answers reads on MDC fall
  task automatic phy_model();
    logic [11:0] hdr;
    logic [15:0] d;
    bit hit;
    forever begin
      @(posedge mdc);
      if (mdio_line === 1'b0) begin
        @(posedge mdc);
        if (mdio_line === 1'b1) begin
          for (int i = 0; i < 12; i++) begin
            @(posedge mdc);
            hdr = {hdr[10:0], mdio_line};
          end
          hit = (hdr[9:5] == PHY_ID);
          if (hdr[11:10] == 2'b10) begin
            d = phy_regs[hdr[4:0]];
            @(negedge mdc);
            @(negedge mdc);
            phy_oe = hit; phy_val = 1'b0;
            for (int i = 15; i >= 0; i--) begin
              @(negedge mdc);
              phy_val = d[i];
            end
            @(negedge mdc);
            phy_oe = 1'b0;
          end else if (hdr[11:10] == 2'b01) begin
            repeat (2) @(posedge mdc);
            for (int i = 0; i < 16; i++) begin
              @(posedge mdc);
              d = {d[14:0], mdio_line};
            end
            if (hit) phy_regs[hdr[4:0]] = d;
          end
        end
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_MODE, v); chk("R1 mode", v, 32'd100);
    rd(A_STAT, v); chk("R1 status", v, 32'd0);
    rd(A_RXD, v);  chk("R1 rxdata", v, 32'd0);
    rd(A_CMD, v);  chk("R1 command", v, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R1 out", {31'd0, mdio_out}, 32'd1);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_ADDR, 32'hFFFF_FFFF); rd(A_ADDR, v); chk("R2 address fields", v, 32'h0000_1F1F);
    wr(A_MODE, 32'h0000_01FF); rd(A_MODE, v); chk("R2 mode bit0 dropped", v, 32'h0000_01FE);
    wr(A_TXD, 32'hABCD_1234);  rd(A_TXD, v);  chk("R2 tx data", v, 32'h0000_1234);
    wr(A_MODE, 32'd4);
  endtask

  task automatic t_write_once();
    logic [31:0] v;
    int s;
    wr(A_ADDR, 32'h0000_0403);
    wr(A_TXD, 32'h0000_A5C3);
    s = oe_edges;
    wr(A_CMD, 32'd4);
    rd(A_STAT, v); chk("R7 busy after write cmd", v, 32'd2);
    wait_stat(1, 1'b0, "R7");
    chk("R4 phy reg written", {16'd0, phy_regs[4]}, 32'h0000_A5C3);
    chk("R4 driven bit times", oe_edges - s, 32'd64);
    s = oe_edges;
    repeat (600) @(negedge clk);
    chk("R7 no replay", oe_edges - s, 32'd0);
    rd(A_STAT, v); chk("R7 idle after frame", v, 32'd0);
    wr(A_CMD, 32'd0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int s;
    s = oe_edges;
    wr(A_CMD, 32'd2);
    wait_stat(1, 1'b0, "R5");
    rd(A_RXD, v); chk("R5 read data", v, 32'h0000_A5C3);
    chk("R5 driven bit times", oe_edges - s, 32'd46);
    wr(A_CMD, 32'd0);
  endtask

  task automatic t_nopre();
    logic [31:0] v;
    int s;
    wr(A_MODE, 32'h0000_0104);
    wr(A_ADDR, 32'h0000_0703);
    wr(A_TXD, 32'h0000_0F0F);
    s = oe_edges;
    wr(A_CMD, 32'd4); wait_stat(1, 1'b0, "R4"); wr(A_CMD, 32'd0);
    chk("R4 no-preamble bit times", oe_edges - s, 32'd32);
    chk("R4 no-preamble data", {16'd0, phy_regs[7]}, 32'h0000_0F0F);
    s = oe_edges;
    wr(A_CMD, 32'd2); wait_stat(1, 1'b0, "R5"); wr(A_CMD, 32'd0);
    chk("R5 no-preamble bit times", oe_edges - s, 32'd14);
    rd(A_RXD, v); chk("R5 no-preamble data", v, 32'h0000_0F0F);
    wr(A_MODE, 32'd4);
  endtask

  task automatic t_bad_phy();
    logic [31:0] v;
    wr(A_ADDR, 32'h0000_0409);
    wr(A_CMD, 32'd2); wait_stat(1, 1'b0, "R5"); wr(A_CMD, 32'd0);
    rd(A_RXD, v); chk("R5 absent phy reads pull-up", v, 32'h0000_FFFF);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    phy_regs[5] = 16'h2222;
    wr(A_ADDR, 32'h0000_0503);
    wr(A_TXD, 32'h0000_1111);
    wr(A_CMD, 32'd6); wait_stat(1, 1'b0, "R8"); wr(A_CMD, 32'd0);
    rd(A_RXD, v); chk("R8 read wins data", v, 32'h0000_2222);
    chk("R8 no write issued", {16'd0, phy_regs[5]}, 32'h0000_2222);
  endtask

  task automatic t_scan();
    logic [31:0] v;
    int s;
    phy_regs[1] = 16'h782D;
    wr(A_ADDR, 32'h0000_0103);
    wr(A_CMD, 32'd1);
    rd(A_STAT, v); chk("R9 invalid and busy at start", v, 32'd6);
    wait_stat(2, 1'b0, "R9");
    rd(A_RXD, v);  chk("R9 scan data", v, 32'h0000_782D);
    rd(A_STAT, v); chk("R10 link up", v, 32'd2);
    phy_regs[1] = 16'h7829;
    wait_stat(0, 1'b1, "R10");
    rd(A_STAT, v); chk("R10 link fail latched, still busy", v, 32'd3);
    rd(A_RXD, v);  chk("R9 scan data refreshed", v, 32'h0000_7829);
    wr(A_CMD, 32'd0);
    wait_stat(1, 1'b0, "R11");
    s = oe_edges;
    repeat (600) @(negedge clk);
    chk("R11 scan stopped", oe_edges - s, 32'd0);
  endtask

  task automatic measure(input logic [31:0] mode, input int exp, input string tag);
    realtime t0;
    int p;
    wr(A_MODE, mode);
    repeat (3) @(posedge mdc);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); p = int'(($realtime - t0) / 10.0);
    chk(tag, p, exp);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0000;
  end

  initial phy_model();

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_write_once();
    t_read();
    t_nopre();
    t_bad_phy();
    t_priority();
    t_scan();
    measure(32'd10, 10, "R3 divider 10");
    measure(32'd11, 10, "R3 odd divider 11");
    measure(32'd0, 2, "R3 divider 0");
    measure(32'd1, 2, "R3 divider 1");
    chk("R6 drive changes off falling edge", r6_bad, 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule